// File: doc/BRIEF.md
# Match-Compare Event Timer

This block is a 32-bit up-counting event timer with a word-wide register bus. Software programs a compare value, chooses a prescale ratio and starts the count. When the count reaches the compare value, the block raises a one-cycle interrupt pulse. An optional auto-reset mode returns the count to zero after a hit, which turns the timer into a periodic tick source.

The count logic runs on a separate, slower timer clock. The registers, the read data and the interrupt live on the bus clock. A write to the clear register sends a toggle request into the timer domain, and an acknowledge toggle comes back. While the two toggles differ, a pending bit in a separate status word stays set. Software polls this bit before it restarts counting. The configuration registers (compare value, control and prescale) are expected to change only while the count is stopped. They reach the timer domain through plain two-stage synchronizers. The count comes back Gray-coded.

Top module: `evt_top`

## Requirements
- R1: While reset is held and right after it, every readable register reads 0, `irq` is 0 and `status_word` is 0.
- R2: The word at byte offset 0x00 (compare value) reads back the value last written. The control word at 0x08 keeps only bits 1:0. The prescale word at 0x10 keeps only bits 1:0. All other bits of those two words read 0, and the clear word at 0x0C reads 0.
- R3: The count word at offset 0x04 is read-only, and writes to it leave the count unchanged.
- R4: Control bit 0 set to 0 freezes the count at its present value. Writing the compare word does not alter the count.
- R5: Prescale code p (0 to 3) makes the count advance once every p+1 timer-clock cycles while control bit 0 is 1.
- R6: Any write to offset 0x0C sets the count to 0, whatever the write data.
- R7: `status_word` bit 10 is 1 from the second bus cycle after a clear write until the clear has been applied in the timer domain and acknowledged. All other status bits stay 0.
- R8: Each time the count steps onto the compare value while control bit 0 is 1, `irq` pulses high for exactly one bus-clock cycle.
- R9: With control bit 1 set, the tick after the count equals the compare value returns the count to 0. The hit period is then compare+1 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| tclk | input | 1 | Timer clock driving the count |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| bus_we | input | 1 | Write strobe for one bus cycle |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| status_word | output | 32 | Status word, bit 10 = clear pending |
| irq | output | 1 | One-cycle compare-hit pulse in the bus domain |

## Verification
Register reads return data one bus edge after the address is presented. The bench therefore samples `bus_rdata` at the falling edge after that rising edge. The pending bit becomes visible two bus edges after the clear write, and its assertion and bench check sample it there. It then falls after two to three timer edges plus a bus-side synchronizer, so the bench polls it with a bounded loop.

A count read also trails the timer domain by a Gray register and two synchronizer stages. Count values are therefore read only after the count is frozen and the chain has settled. Prescale ratios and periodic hits are checked against windows of a few ticks that absorb the start and stop synchronizer delays.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W   = 5;
  localparam int IDX_W    = 3;
  // word indices (byte offset >> 2)
  localparam logic [IDX_W-1:0] IDX_CMP  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CNT  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CTL  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CLR  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_PRE  = 3'd4;
  localparam int PEND_BIT = 10;
  localparam int CTL_RUN  = 0;
  localparam int CTL_AUTO = 1;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/evt_core.sv
module evt_core #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 2,
  parameter int STAGES = 2
) (
  input  logic             tclk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [1:0]       ctl_b,
  input  logic [PRE_W-1:0] pre_b,
  input  logic             clr_tog_b,
  output logic [CNT_W-1:0] cnt_gray,
  output logic             ack_tog,
  output logic             hit_tog
);
  import evt_pkg::*;
  localparam int XW = CNT_W + 2 + PRE_W + 1;

  logic [XW-1:0]    x_s;
  logic [CNT_W-1:0] cmp_t;
  logic [1:0]       ctl_t;
  logic [PRE_W-1:0] pre_t;
  logic             clr_s, clr_d, clr_hit, tick;
  logic [PRE_W-1:0] pcnt;
  logic [CNT_W-1:0] cnt, nxt;

  evt_sync #(.W(XW), .STAGES(STAGES)) u_xs (
    .clk(tclk), .rst(rst), .d({cmp_b, ctl_b, pre_b, clr_tog_b}), .q(x_s)
  );
  assign {cmp_t, ctl_t, pre_t, clr_s} = x_s;

  assign clr_hit = clr_s ^ clr_d;
  assign tick    = ctl_t[CTL_RUN] && (pcnt >= pre_t);
  assign nxt     = (ctl_t[CTL_AUTO] && cnt == cmp_t) ? '0 : cnt + 1'b1;

  always_ff @(posedge tclk) begin
    if (rst) begin
      clr_d    <= 1'b0;
      pcnt     <= '0;
      cnt      <= '0;
      hit_tog  <= 1'b0;
      cnt_gray <= '0;
    end else begin
      clr_d    <= clr_s;
      cnt_gray <= cnt ^ (cnt >> 1);
      if (clr_hit) begin
        pcnt <= '0;
        cnt  <= '0;
      end else if (ctl_t[CTL_RUN]) begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (tick) begin
          cnt <= nxt;
          if (nxt == cmp_t) hit_tog <= ~hit_tog;
        end
      end
    end
  end

  assign ack_tog = clr_d;
endmodule

// File: rtl/evt_regs.sv
module evt_regs #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 2,
  parameter int STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_we,
  input  logic [evt_pkg::ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]          bus_wdata,
  output logic [CNT_W-1:0]          bus_rdata,
  output logic [CNT_W-1:0]          status_word,
  output logic                      irq,
  output logic [CNT_W-1:0]          cmp_r,
  output logic [1:0]                ctl_r,
  output logic [PRE_W-1:0]          pre_r,
  output logic                      clr_tog,
  input  logic [CNT_W-1:0]          cnt_gray_t,
  input  logic                      ack_tog_t,
  input  logic                      hit_tog_t
);
  import evt_pkg::*;

  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] gray_s, cnt_bin, rd_mux;
  logic             ack_s, hit_s, hit_d, pending;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign idx     = bus_addr[ADDR_W-1:2];

  evt_sync #(.W(CNT_W), .STAGES(STAGES)) u_cs (
    .clk(clk), .rst(rst), .d(cnt_gray_t), .q(gray_s)
  );
  evt_sync #(.W(2), .STAGES(STAGES)) u_fs (
    .clk(clk), .rst(rst), .d({ack_tog_t, hit_tog_t}), .q({ack_s, hit_s})
  );

  always_comb begin
    cnt_bin[CNT_W-1] = gray_s[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) cnt_bin[i] = cnt_bin[i+1] ^ gray_s[i];
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (idx)
        IDX_CMP: rd_mux = cmp_r;
        IDX_CNT: rd_mux = cnt_bin;
        IDX_CTL: rd_mux = {{(CNT_W-2){1'b0}}, ctl_r};
        IDX_PRE: rd_mux = {{(CNT_W-PRE_W){1'b0}}, pre_r};
        default: rd_mux = '0;
      endcase
    end
  end

  assign pending = clr_tog ^ ack_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_r       <= '0;
      ctl_r       <= '0;
      pre_r       <= '0;
      clr_tog     <= 1'b0;
      hit_d       <= 1'b0;
      irq         <= 1'b0;
      bus_rdata   <= '0;
      status_word <= '0;
    end else begin
      if (bus_we && aligned) begin
        case (idx)
          IDX_CMP: cmp_r   <= bus_wdata;
          IDX_CTL: ctl_r   <= bus_wdata[1:0];
          IDX_CLR: clr_tog <= ~clr_tog;
          IDX_PRE: pre_r   <= bus_wdata[PRE_W-1:0];
          default: ;
        endcase
      end
      hit_d       <= hit_s;
      irq         <= hit_s ^ hit_d;
      bus_rdata   <= rd_mux;
      status_word <= '0;
      status_word[PEND_BIT] <= pending;
    end
  end
endmodule

// File: rtl/evt_top.sv
module evt_top #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 2,
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        tclk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [31:0] status_word,
  output logic        irq
);
  logic [CNT_W-1:0] cmp_r, cnt_gray;
  logic [1:0]       ctl_r;
  logic [PRE_W-1:0] pre_r;
  logic             clr_tog, ack_tog, hit_tog;

  evt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .STAGES(STAGES)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_word(status_word),
    .irq(irq), .cmp_r(cmp_r), .ctl_r(ctl_r), .pre_r(pre_r), .clr_tog(clr_tog),
    .cnt_gray_t(cnt_gray), .ack_tog_t(ack_tog), .hit_tog_t(hit_tog)
  );

  evt_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .STAGES(STAGES)) u_core (
    .tclk(tclk), .rst(rst), .cmp_b(cmp_r), .ctl_b(ctl_r), .pre_b(pre_r),
    .clr_tog_b(clr_tog), .cnt_gray(cnt_gray), .ack_tog(ack_tog),
    .hit_tog(hit_tog)
  );
endmodule

// File: rtl/evt_chk.sv
module evt_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_we,
  input logic [4:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] status_word,
  input logic        irq
);
  // R1: the cycle after a reset cycle shows quiet outputs
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!irq && status_word == 32'h0 && bus_rdata == 32'h0));

  // R2: compare word reads back what was written
  a_r2_cmp_readback: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 5'h00) ##1 (!bus_we && bus_addr == 5'h00)
      |=> bus_rdata == $past(bus_wdata, 2));

  // R2: control word keeps only two bits
  a_r2_ctl_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == 5'h08) |-> bus_rdata[31:2] == 30'h0);

  // R7: pending visible two bus edges after a clear write
  a_r7_pending_after_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 5'h0C) |=> ##1 status_word[10]);

  // R7: only bit 10 of the status word is ever used
  a_r7_status_bits: assert property (@(posedge clk) disable iff (rst)
    (status_word[31:11] == 21'h0 && status_word[9:0] == 10'h0));

  // R8: interrupt pulse lasts one bus cycle
  a_r8_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

bind evt_top evt_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_word(status_word),
  .irq(irq)
);

// File: tb/sim_evt_top.sv
module sim_evt_top;
  localparam int CLK_P  = 10;
  localparam int TCLK_P = 26;

  logic        clk = 1'b0, tclk = 1'b0, rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, status_word;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  int irq_hi = 0, irq_rise = 0;
  logic irq_prev = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always #(TCLK_P/2) tclk = ~tclk;

  evt_top u0 (
    .clk(clk), .tclk(tclk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_word(status_word),
    .irq(irq)
  );

  always @(negedge clk) begin
    if (irq) irq_hi++;
    if (irq && !irq_prev) irq_rise++;
    irq_prev <= irq;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_clear;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!status_word[10]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic settle;
    repeat (6) @(posedge tclk);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(status_word == 0, "R1 status", status_word, 0);
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), v);
      chk(v == 0, "R1 reg", v, 0);
    end
  endtask

  task automatic t_readback;
    logic [31:0] v;
    wr(5'h00, 32'h1234_5678); rd(5'h00, v);
    chk(v == 32'h1234_5678, "R2 cmp", v, 32'h1234_5678);
    wr(5'h08, 32'hFFFF_FFFE); rd(5'h08, v);
    chk(v == 32'h2, "R2 ctl", v, 2);
    wr(5'h08, 32'h0);
    wr(5'h10, 32'hFFFF_FFF1); rd(5'h10, v);
    chk(v == 32'h1, "R2 pre", v, 1);
    rd(5'h0C, v);
    chk(v == 0, "R2 clr reads zero", v, 0);
    wr(5'h10, 32'h0);
  endtask

  task automatic t_freeze;
    logic [31:0] c1, v;
    wr(5'h00, 32'hFFFF_0000);
    wr(5'h0C, 32'h0); wait_clear;
    wr(5'h08, 32'h1);
    repeat (60) @(posedge tclk);
    wr(5'h08, 32'h0);
    settle;
    rd(5'h04, c1);
    chk(c1 >= 55 && c1 <= 65, "R5 divide by 1", c1, 60);
    wr(5'h00, 32'h7);
    settle;
    rd(5'h04, v);
    chk(v == c1, "R4 cmp write keeps count", v, c1);
    wr(5'h04, 32'hFFFF);
    settle;
    rd(5'h04, v);
    chk(v == c1, "R3 count read-only", v, c1);
    repeat (40) @(posedge tclk);
    rd(5'h04, v);
    chk(v == c1, "R4 frozen", v, c1);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(5'h0C, 32'hDEAD_BEEF);
    @(negedge clk);
    chk(status_word[10] == 1'b1, "R7 pending set", status_word[10], 1);
    wait_clear;
    chk(status_word[10] == 1'b0, "R7 pending drops", status_word[10], 0);
    settle;
    rd(5'h04, v);
    chk(v == 0, "R6 clear", v, 0);
  endtask

  task automatic t_prescale(input int code, input int tcycles);
    logic [31:0] v;
    int exp;
    exp = tcycles / (code + 1);
    wr(5'h10, 32'(code));
    wr(5'h0C, 32'h0); wait_clear;
    wr(5'h08, 32'h1);
    repeat (tcycles) @(posedge tclk);
    wr(5'h08, 32'h0);
    settle;
    rd(5'h04, v);
    chk(int'(v) >= exp - 6 && int'(v) <= exp + 4, "R5 prescale", v, exp);
    wr(5'h10, 32'h0);
  endtask

  task automatic t_match;
    wr(5'h00, 32'd50);
    wr(5'h0C, 32'h0); wait_clear;
    irq_hi = 0; irq_rise = 0;
    wr(5'h08, 32'h1);
    repeat (200) @(posedge tclk);
    wr(5'h08, 32'h0);
    settle;
    chk(irq_rise == 1, "R8 one hit", irq_rise, 1);
    chk(irq_hi == irq_rise, "R8 one-cycle pulse", irq_hi, irq_rise);
  endtask

  task automatic t_auto;
    logic [31:0] v;
    wr(5'h00, 32'd9);
    wr(5'h0C, 32'h0); wait_clear;
    irq_hi = 0; irq_rise = 0;
    wr(5'h08, 32'h3);
    repeat (220) @(posedge tclk);
    wr(5'h08, 32'h2);
    settle;
    chk(irq_rise >= 21 && irq_rise <= 23, "R9 period", irq_rise, 22);
    chk(irq_hi == irq_rise, "R8 pulse width in auto mode", irq_hi, irq_rise);
    rd(5'h04, v);
    chk(v <= 9, "R9 count bounded", v, 9);
    wr(5'h08, 32'h0);
  endtask

  initial begin
    repeat (12) @(negedge clk);
    t_reset;
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset;
    t_readback;
    t_freeze;
    t_clear;
    t_prescale(3, 400);
    t_prescale(1, 200);
    t_match;
    t_auto;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule